// File: doc/BRIEF.md
# AFC Sequencer

This block runs one automatic frequency correction (AFC) pass for a receiver's local-oscillator frequency word. A pass starts in one of two ways. In automatic mode it starts on each rising edge of the receiver-enable input. In manual mode it starts on a one-cycle software start pulse. Once a pass has started, the block optionally zeroes the correction it has built up so far. It then moves the channel-filter bandwidth select to a wider, alternate code and sends a one-cycle request to an external frequency-error estimator. It waits for that estimator's valid strobe and takes its signed result.

In the apply step, the result is added to the stored correction. The frequency output is rewritten as the programmed base word minus the stored correction, plus an optional low-modulation-index offset. The offset is given in counts of 488 Hz, which is 8 LSBs of the 24-bit word, whose LSB is about 61 Hz. All arithmetic on the word wraps modulo 2^24.

While no pass is running, the frequency output follows the base word, the correction and the offset, one cycle after they change. A registered warning flag shows when the enabled offset is not larger than the programmed DC-canceller cutoff, measured in the same units.

Top module: `afc_ctrl`

## Requirements
- R1: When `auto_en` is 1, a rising edge on `rx_en` starts a pass; when `auto_en` is 0, edges on `rx_en` start nothing.
- R2: When `auto_en` is 0, a one-cycle `sw_start` pulse starts a pass; when `auto_en` is 1, `sw_start` has no effect.
- R3: A pass started in automatic mode with `auto_clr` = 1 zeroes the stored correction before the new estimate is added. Any other pass adds the estimate to the previous correction.
- R4: Outside a pass, `freq_out` equals `base_freq` minus the stored correction plus the offset term, modulo 2^24, one cycle after the inputs change. During a pass, `freq_out` holds until the apply step writes the corrected value.
- R5: `bw_sel` equals `afc_bw_code` from the cycle after the start until the pass completes, and equals `rx_bw_code` at all other times.
- R6: `est_req` is high for exactly one cycle per pass. `est_value` is taken only on a cycle where `est_valid` is high after that request.
- R7: When `lb_en` is 1, the offset term is `lb_ofs` × 8 LSBs (488 Hz per count); when `lb_en` is 0, the offset term is zero.
- R8: One cycle after its inputs change, `cfg_warn` is 1 exactly when `lb_en` is 1 and `lb_ofs` ≤ `dcc_cut` (unsigned, same units).
- R9: `done_pulse` is high for one cycle when a pass completes. `done` stays high from then until the next pass starts.
- R10: A start condition arriving while a pass is running is ignored: no second request and no second completion.
- R11: While `rst_n` is low, `freq_out`, `est_req`, `done`, `done_pulse` and `cfg_warn` are 0 and `bw_sel` equals `rx_bw_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1: start on receiver enable; 0: start on software pulse |
| auto_clr | input | 1 | Zero the correction on automatic starts |
| sw_start | input | 1 | Software start pulse (manual mode) |
| rx_en | input | 1 | Receiver enable level |
| base_freq | input | 24 | Programmed carrier frequency word |
| rx_bw_code | input | 5 | Normal channel-filter bandwidth code |
| afc_bw_code | input | 5 | Bandwidth code used during a pass |
| lb_en | input | 1 | Low-beta offset enable |
| lb_ofs | input | 8 | Low-beta offset, 488 Hz per count |
| dcc_cut | input | 8 | DC-canceller cutoff, 488 Hz per count |
| est_req | output | 1 | One-cycle request to the estimator |
| est_valid | input | 1 | Estimator result strobe |
| est_value | input | 16 | Signed frequency-error estimate |
| freq_out | output | 24 | Effective corrected frequency word |
| bw_sel | output | 5 | Selected bandwidth code |
| done | output | 1 | Last pass complete |
| done_pulse | output | 1 | One-cycle completion strobe |
| cfg_warn | output | 1 | Low-beta offset not above DC-canceller cutoff |

## Verification
The hardest case to reach is a start condition that arrives while a pass is stalled waiting for the estimator, which is the case R10 guards against. The bench holds back the valid strobe for a random number of cycles. In that gap it pulses `sw_start` and re-raises `rx_en`, then checks that exactly one completion occurs and that the correction builds up only once. Randomised passes mix the two modes, the clear setting, signed estimates at the 16-bit limits and base words near the wrap point. The bench compares each completed pass against a running model of the correction.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_CLEAR      = 3'd1,
    ST_REQUEST    = 3'd2,
    ST_WAIT_VALID = 3'd3,
    ST_APPLY      = 3'd4,
    ST_DONE       = 3'd5
  } afc_state_e;
endpackage

// File: rtl/afc_trigger.sv
module afc_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic auto_clr,
  input  logic sw_start,
  input  logic rx_en,
  input  logic idle_ok,
  output logic launch,
  output logic launch_clear
);
  logic rx_q;
  logic rx_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_en;
  end

  always_comb begin
    rx_rise      = rx_en & ~rx_q;
    launch       = idle_ok & (auto_en ? rx_rise : sw_start);
    launch_clear = launch & auto_en & auto_clr;
  end
endmodule

// File: rtl/afc_fsm.sv
module afc_fsm
  import afc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_clear,
  input  logic est_valid,
  output logic idle_ok,
  output logic busy,
  output logic est_req,
  output logic capture,
  output logic do_clear,
  output logic do_apply,
  output logic done,
  output logic done_pulse
);
  afc_state_e state_q, state_d;
  logic       pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (launch) state_d = launch_clear ? ST_CLEAR : ST_REQUEST;
      ST_CLEAR:         state_d = ST_REQUEST;
      ST_REQUEST:       state_d = ST_WAIT_VALID;
      ST_WAIT_VALID:    if (est_valid) state_d = ST_APPLY;
      ST_APPLY:         state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
    pulse_d = (state_d == ST_DONE) && (state_q != ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    idle_ok    = (state_q == ST_IDLE) || (state_q == ST_DONE);
    busy       = !idle_ok;
    est_req    = (state_q == ST_REQUEST);
    capture    = (state_q == ST_WAIT_VALID) && est_valid;
    do_clear   = (state_q == ST_CLEAR);
    do_apply   = (state_q == ST_APPLY);
    done       = (state_q == ST_DONE);
    done_pulse = pulse_q;
  end

  a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    est_req |=> !est_req);
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  a_r9_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done);
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_VALID && !est_valid) |=> (state_q == ST_WAIT_VALID));
endmodule

// File: rtl/afc_datapath.sv
module afc_datapath #(
  parameter int FREQ_W    = 24,
  parameter int EST_W     = 16,
  parameter int OFS_W     = 8,
  parameter int OFS_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] base_freq,
  input  logic [EST_W-1:0]  est_value,
  input  logic              capture,
  input  logic              do_clear,
  input  logic              do_apply,
  input  logic              track,
  input  logic              lb_en,
  input  logic [OFS_W-1:0]  lb_ofs,
  input  logic [OFS_W-1:0]  dcc_cut,
  output logic [FREQ_W-1:0] freq_out,
  output logic              cfg_warn
);
  logic [EST_W-1:0]  est_q;
  logic [FREQ_W-1:0] est_ext;
  logic [FREQ_W-1:0] acc_q, acc_d, acc_sum;
  logic [FREQ_W-1:0] ofs_term;
  logic [FREQ_W-1:0] freq_q, freq_d;
  logic              warn_q, warn_d;
  logic              acc_en, freq_en;

  generate
    if (EST_W < FREQ_W) begin : g_sext
      assign est_ext = {{(FREQ_W-EST_W){est_q[EST_W-1]}}, est_q};
    end else begin : g_trunc
      assign est_ext = est_q[FREQ_W-1:0];
    end
  endgenerate

  generate
    if (OFS_W + OFS_SHIFT <= FREQ_W) begin : g_ofs_fit
      assign ofs_term = lb_en ? (FREQ_W'(lb_ofs) << OFS_SHIFT) : '0;
    end else begin : g_ofs_wrap
      logic [OFS_W+OFS_SHIFT-1:0] ofs_wide;
      assign ofs_wide = {lb_ofs, {OFS_SHIFT{1'b0}}};
      assign ofs_term = lb_en ? ofs_wide[FREQ_W-1:0] : '0;
    end
  endgenerate

  always_comb begin
    acc_sum = acc_q + est_ext;
    acc_en  = do_clear | do_apply;
    acc_d   = do_clear ? '0 : acc_sum;
    freq_en = track | do_apply;
    freq_d  = base_freq - (do_apply ? acc_sum : acc_q) + ofs_term;
    warn_d  = lb_en && (lb_ofs <= dcc_cut);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q  <= '0;
      acc_q  <= '0;
      freq_q <= '0;
      warn_q <= 1'b0;
    end else begin
      if (capture) est_q  <= est_value;
      if (acc_en)  acc_q  <= acc_d;
      if (freq_en) freq_q <= freq_d;
      warn_q <= warn_d;
    end
  end

  assign freq_out = freq_q;
  assign cfg_warn = warn_q;

  a_r4_hold_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!track && !do_apply) |=> $stable(freq_out));
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (acc_q == '0));
endmodule

// File: rtl/afc_ctrl.sv
module afc_ctrl #(
  parameter int FREQ_W    = 24,
  parameter int EST_W     = 16,
  parameter int OFS_W     = 8,
  parameter int BW_W      = 5,
  parameter int OFS_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              auto_clr,
  input  logic              sw_start,
  input  logic              rx_en,
  input  logic [FREQ_W-1:0] base_freq,
  input  logic [BW_W-1:0]   rx_bw_code,
  input  logic [BW_W-1:0]   afc_bw_code,
  input  logic              lb_en,
  input  logic [OFS_W-1:0]  lb_ofs,
  input  logic [OFS_W-1:0]  dcc_cut,
  output logic              est_req,
  input  logic              est_valid,
  input  logic [EST_W-1:0]  est_value,
  output logic [FREQ_W-1:0] freq_out,
  output logic [BW_W-1:0]   bw_sel,
  output logic              done,
  output logic              done_pulse,
  output logic              cfg_warn
);
  logic idle_ok, busy, launch, launch_clear;
  logic capture, do_clear, do_apply;

  afc_trigger u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_en      (auto_en),
    .auto_clr     (auto_clr),
    .sw_start     (sw_start),
    .rx_en        (rx_en),
    .idle_ok      (idle_ok),
    .launch       (launch),
    .launch_clear (launch_clear)
  );

  afc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_clear (launch_clear),
    .est_valid    (est_valid),
    .idle_ok      (idle_ok),
    .busy         (busy),
    .est_req      (est_req),
    .capture      (capture),
    .do_clear     (do_clear),
    .do_apply     (do_apply),
    .done         (done),
    .done_pulse   (done_pulse)
  );

  afc_datapath #(
    .FREQ_W    (FREQ_W),
    .EST_W     (EST_W),
    .OFS_W     (OFS_W),
    .OFS_SHIFT (OFS_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_freq (base_freq),
    .est_value (est_value),
    .capture   (capture),
    .do_clear  (do_clear),
    .do_apply  (do_apply),
    .track     (idle_ok),
    .lb_en     (lb_en),
    .lb_ofs    (lb_ofs),
    .dcc_cut   (dcc_cut),
    .freq_out  (freq_out),
    .cfg_warn  (cfg_warn)
  );

  assign bw_sel = busy ? afc_bw_code : rx_bw_code;

  a_r1_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (bw_sel == afc_bw_code));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !est_req);
endmodule

// File: tb/afc_ctrl_test.sv
module afc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        auto_en, auto_clr, sw_start, rx_en;
  logic [23:0] base_freq;
  logic [4:0]  rx_bw_code, afc_bw_code;
  logic        lb_en;
  logic [7:0]  lb_ofs, dcc_cut;
  logic        est_req, est_valid;
  logic [15:0] est_value;
  logic [23:0] freq_out;
  logic [4:0]  bw_sel;
  logic        done, done_pulse, cfg_warn;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [23:0] acc_m = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  afc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .auto_clr(auto_clr),
    .sw_start(sw_start), .rx_en(rx_en), .base_freq(base_freq),
    .rx_bw_code(rx_bw_code), .afc_bw_code(afc_bw_code), .lb_en(lb_en),
    .lb_ofs(lb_ofs), .dcc_cut(dcc_cut), .est_req(est_req),
    .est_valid(est_valid), .est_value(est_value), .freq_out(freq_out),
    .bw_sel(bw_sel), .done(done), .done_pulse(done_pulse), .cfg_warn(cfg_warn)
  );

  function automatic logic [23:0] exp_freq();
    logic [23:0] ofs;
    ofs = lb_en ? {13'd0, lb_ofs, 3'b000} : 24'd0;
    return base_freq - acc_m + ofs;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic run_pass(input bit am, input bit ac, input logic [15:0] est,
                          input int dly, input bit poke);
    logic [23:0] prev;
    int pulses;
    auto_en = am; auto_clr = ac; rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    prev = freq_out;
    if (am) rx_en = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    chk("R5 alternate bandwidth in pass", bw_sel, afc_bw_code);
    for (int k = 0; k < 4; k++) begin
      if (est_req) break;
      @(negedge clk);
    end
    chk("R6 request issued (R1/R2 start)", est_req, 1);
    chk("R4 freq held during pass", freq_out, prev);
    @(negedge clk);
    chk("R6 request lasts one cycle", est_req, 0);
    pulses = 0;
    for (int k = 0; k < dly; k++) begin
      if (poke && k == 0) begin sw_start = 1'b1; rx_en = 1'b0; end
      if (poke && k == 1) begin sw_start = 1'b0; rx_en = 1'b1; end
      @(negedge clk);
      if (est_req) pulses++;
    end
    sw_start = 1'b0;
    chk("R10 no second request while waiting", pulses, 0);
    est_valid = 1'b1; est_value = est;
    @(negedge clk);
    est_valid = 1'b0; est_value = 16'($urandom);
    for (int k = 0; k < 5; k++) begin
      if (done_pulse) break;
      @(negedge clk);
    end
    if (am && ac) acc_m = '0;
    acc_m = acc_m + {{8{est[15]}}, est};
    chk("R9 done pulse", done_pulse, 1);
    chk("R3/R4 corrected freq", freq_out, exp_freq());
    chk("R5 normal bandwidth after pass", bw_sel, rx_bw_code);
    @(negedge clk);
    chk("R9 pulse one cycle", done_pulse, 0);
    chk("R9 done held", done, 1);
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (est_req || done_pulse) pulses++;
    end
    chk("R10 ignored start caused no second pass", pulses, 0);
    chk("R4 freq stable after pass", freq_out, exp_freq());
    rx_en = 1'b0;
  endtask

  task automatic no_start(input bit am, input string req);
    int seen;
    auto_en = am; rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (am) sw_start = 1'b1; else rx_en = 1'b1;
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sw_start = 1'b0;
      if (est_req || bw_sel != rx_bw_code) seen++;
    end
    chk(req, seen, 0);
    rx_en = 1'b0;
  endtask

  initial begin
    wait (cyc >= 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; auto_en = 1'b1; auto_clr = 1'b0; sw_start = 1'b0; rx_en = 1'b0;
    base_freq = 24'hE4C000; rx_bw_code = 5'd10; afc_bw_code = 5'd3;
    lb_en = 1'b0; lb_ofs = 8'd0; dcc_cut = 8'd0; est_valid = 1'b0; est_value = '0;
    repeat (3) @(negedge clk);
    chk("R11 freq_out in reset", freq_out, 0);
    chk("R11 est_req in reset", est_req, 0);
    chk("R11 done in reset", done, 0);
    chk("R11 done_pulse in reset", done_pulse, 0);
    chk("R11 cfg_warn in reset", cfg_warn, 0);
    chk("R11 bw_sel in reset", bw_sel, rx_bw_code);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 tracks base after reset", freq_out, exp_freq());

    lb_en = 1'b1; lb_ofs = 8'h25; dcc_cut = 8'h25;
    @(negedge clk);
    chk("R7 offset 8 LSB per count", freq_out, exp_freq());
    chk("R8 warn when offset equals cutoff", cfg_warn, 1);
    dcc_cut = 8'h24;
    @(negedge clk);
    chk("R8 no warn when offset above cutoff", cfg_warn, 0);
    dcc_cut = 8'hFF; lb_en = 1'b0;
    @(negedge clk);
    chk("R8 no warn when disabled", cfg_warn, 0);
    chk("R7 no offset when disabled", freq_out, exp_freq());

    no_start(1'b0, "R1 rx_en edge ignored in manual mode");
    no_start(1'b1, "R2 sw_start ignored in automatic mode");

    run_pass(1'b1, 1'b0, 16'h0123, 1, 1'b0);
    run_pass(1'b1, 1'b0, 16'hFF00, 2, 1'b0);
    run_pass(1'b1, 1'b1, 16'h0040, 0, 1'b0);
    run_pass(1'b0, 1'b1, 16'h0011, 3, 1'b1);
    base_freq = 24'h000010; lb_en = 1'b1; lb_ofs = 8'hFF;
    run_pass(1'b1, 1'b1, 16'h7FFF, 4, 1'b1);
    base_freq = 24'hFFFFF0; lb_en = 1'b0;
    run_pass(1'b0, 1'b0, 16'h8000, 2, 1'b1);

    for (int i = 0; i < 30; i++) begin
      if (($urandom % 3) == 0) begin
        base_freq = 24'($urandom); lb_en = 1'($urandom); lb_ofs = 8'($urandom);
        dcc_cut = 8'($urandom);
        @(negedge clk);
        chk("R4 tracking in idle", freq_out, exp_freq());
        chk("R8 warning", cfg_warn, lb_en && (lb_ofs <= dcc_cut));
      end
      run_pass(1'($urandom), 1'($urandom), 16'($urandom),
               2 + int'($urandom % 5), 1'($urandom));
    end
    summary();
  end
endmodule